// File: doc/BRIEF.md
# Double-Precision NaN Classifier and Quieter

This unit inspects a 64-bit IEEE-754 double operand and reports which of six categories it belongs to: signed zero, subnormal, normal, infinity, quiet NaN or signaling NaN. A per-operand mode bit chooses how the top fraction bit of a NaN is read. In the legacy encoding a set top fraction bit marks the NaN as signaling. In the 2008 encoding a clear top fraction bit marks it as signaling.

When the caller asks for quieting, the unit also returns a quiet form of any signaling NaN and raises an invalid-operation flag. Any other operand comes back unchanged and the flag stays low. All results are registered one cycle after a valid input, and an output valid marks them.

Top module: `fp_nanq_unit`

## Requirements
- R1: After a synchronous active-high reset, `res_vld`, `res_cls`, `res_val` and `res_inv` are all zero.
- R2: One cycle after `op_vld` is high, `res_vld` is high. When `op_vld` is low, `res_vld` is low in the following cycle.
- R3: `res_cls` is one-hot whenever `res_vld` is high. Its bit positions are [5] signaling NaN, [4] quiet NaN, [3] infinity, [2] normal, [1] subnormal and [0] zero.
- R4: An exponent field (bits 62:52) of zero gives class zero when the fraction (bits 51:0) is zero, and class subnormal otherwise. A nonzero exponent that is not all ones gives class normal.
- R5: An all-ones exponent with a zero fraction gives class infinity. An all-ones exponent with a nonzero fraction gives a NaN.
- R6: A NaN is signaling exactly when `op_mode08` XOR fraction bit 51 equals 1. Otherwise it is quiet.
- R7: With `op_quiet` high and a signaling NaN in 2008 mode, `res_val` is the operand with bit 51 set.
- R8: With `op_quiet` high and a signaling NaN in legacy mode, `res_val` is the operand with bit 51 cleared. If that leaves the fraction all zero, bit 50 is also set.
- R9: `res_inv` is high exactly when `op_quiet` was high and the operand was a signaling NaN.
- R10: For any operand that is not a signaling NaN, or whenever `op_quiet` is low, `res_val` equals the operand unchanged. The sign bit (63) is never altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operand valid |
| op_data | input | 64 | Double-precision operand |
| op_mode08 | input | 1 | 1 = 2008 NaN encoding, 0 = legacy encoding |
| op_quiet | input | 1 | Request conversion of a signaling NaN to a quiet NaN |
| res_vld | output | 1 | Result valid |
| res_cls | output | 6 | One-hot class code |
| res_val | output | 64 | Operand, quieted when requested |
| res_inv | output | 1 | Invalid-operation flag |

## Verification
The bench drives NaNs whose only set fraction bit is bit 51 in legacy mode. Quieting such a NaN clears its whole fraction, so a design that skipped the bit-50 repair would return infinity instead of a NaN. The bench runs each NaN pattern under both mode values. A design that read the quiet bit with fixed polarity would then swap the quiet-NaN and signaling-NaN classes and raise the flag on the wrong operands.

The bench also covers the category boundaries:
- the largest subnormal,
- the smallest normal,
- the largest finite value,
- both infinities.

A design that compared the exponent against the wrong limit would misfile these. Quiet requests on non-signaling operands and unrequested signaling operands check that the value passes through unchanged and the flag stays low. Negative NaNs check that the sign survives quieting.

// File: rtl/fp_nanq_pkg.sv
package fp_nanq_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int CLS_W  = 6;

  typedef enum logic [2:0] {
    K_ZERO = 3'd0,
    K_SUB  = 3'd1,
    K_NORM = 3'd2,
    K_INF  = 3'd3,
    K_QNAN = 3'd4,
    K_SNAN = 3'd5
  } kind_e;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
  } dword_t;
endpackage

// File: rtl/fp_nanq_classify.sv
module fp_nanq_classify
  import fp_nanq_pkg::*;
(
  input  dword_t x,
  input  logic   mode08,
  output kind_e  kind
);
  logic ex_ones, ex_zero, fr_zero, top_bit;

  always_comb begin
    ex_ones = &x.ex;
    ex_zero = ~|x.ex;
    fr_zero = ~|x.fr;
    top_bit = x.fr[FRAC_W-1];

    if (ex_zero)      kind = fr_zero ? K_ZERO : K_SUB;
    else if (!ex_ones) kind = K_NORM;
    else if (fr_zero) kind = K_INF;
    else              kind = (mode08 ^ top_bit) ? K_SNAN : K_QNAN;
  end
endmodule

// File: rtl/fp_nanq_quiet.sv
module fp_nanq_quiet
  import fp_nanq_pkg::*;
(
  input  dword_t x,
  input  logic   mode08,
  input  logic   do_quiet,
  input  kind_e  kind,
  output dword_t y,
  output logic   inv
);
  localparam int QB = FRAC_W - 1;
  localparam int RB = FRAC_W - 2;

  dword_t q;

  always_comb begin
    q = x;
    if (mode08) begin
      q.fr[QB] = 1'b1;
    end else begin
      q.fr[QB] = 1'b0;
      if (~|q.fr) q.fr[RB] = 1'b1;
    end
    inv = do_quiet && (kind == K_SNAN);
    y   = inv ? q : x;
  end
endmodule

// File: rtl/fp_nanq_unit.sv
module fp_nanq_unit
  import fp_nanq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_vld,
  input  logic [DATA_W-1:0] op_data,
  input  logic              op_mode08,
  input  logic              op_quiet,
  output logic              res_vld,
  output logic [CODE_W-1:0] res_cls,
  output logic [DATA_W-1:0] res_val,
  output logic              res_inv
);
  dword_t x, y;
  kind_e  kind;
  logic   inv;
  logic [CODE_W-1:0] onehot;

  assign x = dword_t'(op_data);

  fp_nanq_classify u_cls (
    .x(x), .mode08(op_mode08), .kind(kind)
  );

  fp_nanq_quiet u_qt (
    .x(x), .mode08(op_mode08), .do_quiet(op_quiet), .kind(kind),
    .y(y), .inv(inv)
  );

  always_comb begin
    onehot = '0;
    onehot[kind] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_cls <= '0;
      res_val <= '0;
      res_inv <= 1'b0;
    end else begin
      res_vld <= op_vld;
      if (op_vld) begin
        res_cls <= onehot;
        res_val <= DATA_W'(y);
        res_inv <= inv;
      end else begin
        res_inv <= 1'b0;
      end
    end
  end
endmodule

module fp_nanq_chk #(
  parameter int DATA_W = 64,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              op_vld,
  input logic [DATA_W-1:0] op_data,
  input logic              op_quiet,
  input logic              res_vld,
  input logic [CODE_W-1:0] res_cls,
  input logic [DATA_W-1:0] res_val,
  input logic              res_inv
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> res_vld);
  // R3
  cls_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $countones(res_cls) == 1);
  // R9
  inv_snan_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_inv) |-> res_cls[5]);
  // R10
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> res_val[DATA_W-1] == $past(op_data[DATA_W-1]));
  // R9
  inv_req_chk: assert property (@(posedge clk) disable iff (rst)
    (op_vld && !op_quiet) |=> !res_inv);
endmodule

bind fp_nanq_unit fp_nanq_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .op_vld(op_vld), .op_data(op_data),
  .op_quiet(op_quiet), .res_vld(res_vld), .res_cls(res_cls),
  .res_val(res_val), .res_inv(res_inv)
);

// File: tb/test_fp_nanq_unit.sv
module test_fp_nanq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst;
  logic        op_vld;
  logic [63:0] op_data;
  logic        op_mode08;
  logic        op_quiet;
  logic        res_vld;
  logic [5:0]  res_cls;
  logic [63:0] res_val;
  logic        res_inv;

  int compared = 0;
  int mismatched = 0;

  fp_nanq_unit i_fp_nanq_unit (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_data(op_data),
    .op_mode08(op_mode08), .op_quiet(op_quiet),
    .res_vld(res_vld), .res_cls(res_cls), .res_val(res_val), .res_inv(res_inv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    compared++;
    if (act !== exp_v) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // behavioural reference
  function automatic logic [5:0] ref_cls(input logic [63:0] d, input bit m);
    int e = int'(d[62:52]);
    bit fz = (d[51:0] == 0);
    if (e == 0) return fz ? 6'b000001 : 6'b000010;
    if (e != 2047) return 6'b000100;
    if (fz) return 6'b001000;
    if ((m ? 1 : 0) != (d[51] ? 1 : 0)) return 6'b100000;
    return 6'b010000;
  endfunction

  task automatic apply(input logic [63:0] d, input bit m, input bit q, input string tag);
    logic [5:0]  ec;
    logic [63:0] ev;
    bit          ei;
    ec = ref_cls(d, m);
    ei = q && ec == 6'b100000;
    ev = d;
    if (ei) begin
      if (m) ev[51] = 1'b1;
      else begin
        ev[51] = 1'b0;
        if (ev[51:0] == 0) ev[50] = 1'b1;
      end
    end
    @(negedge clk);
    op_vld = 1; op_data = d; op_mode08 = m; op_quiet = q;
    @(negedge clk);
    op_vld = 0;
    chk({"R2 ", tag}, 64'(res_vld), 64'd1);
    chk({"R3 R4 R5 R6 cls ", tag}, 64'(res_cls), 64'(ec));
    chk({"R7 R8 R10 val ", tag}, res_val, ev);
    chk({"R9 inv ", tag}, 64'(res_inv), 64'(ei));
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1; op_vld = 0; op_data = '0; op_mode08 = 0; op_quiet = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vld", 64'(res_vld), 0);
    chk("R1 cls", 64'(res_cls), 0);
    chk("R1 val", res_val, 0);
    chk("R1 inv", 64'(res_inv), 0);
    rst = 0;
    @(negedge clk);
    chk("R2 idle", 64'(res_vld), 0);

    for (int m = 0; m < 2; m++) begin
      for (int q = 0; q < 2; q++) begin
        apply(64'h0000000000000000, m[0], q[0], "R4 +zero");
        apply(64'h8000000000000000, m[0], q[0], "R4 -zero");
        apply(64'h000FFFFFFFFFFFFF, m[0], q[0], "R4 max sub");
        apply(64'h0010000000000000, m[0], q[0], "R4 min norm");
        apply(64'h7FEFFFFFFFFFFFFF, m[0], q[0], "R4 max fin");
        apply(64'h7FF0000000000000, m[0], q[0], "R5 +inf");
        apply(64'hFFF0000000000000, m[0], q[0], "R5 -inf");
        apply(64'h7FF8000000000000, m[0], q[0], "R6 R8 bit51 only");
        apply(64'hFFF8000000000000, m[0], q[0], "R10 neg bit51 only");
        apply(64'h7FF0000000000001, m[0], q[0], "R6 R7 low frac");
        apply(64'h7FFC000000000123, m[0], q[0], "R8 bits51+50");
        apply(64'hFFF4000000000000, m[0], q[0], "R7 neg bit50");
      end
    end
    // back-to-back stream, then idle gap
    @(negedge clk);
    op_vld = 1; op_data = 64'h7FF8000000000000; op_mode08 = 0; op_quiet = 1;
    @(negedge clk);
    op_data = 64'h3FF0000000000000;
    chk("R8 stream", res_val, 64'h7FF4000000000000);
    chk("R9 stream", 64'(res_inv), 1);
    @(negedge clk);
    op_vld = 0;
    chk("R10 stream", res_val, 64'h3FF0000000000000);
    chk("R3 stream", 64'(res_cls), 64'h04);
    @(negedge clk);
    chk("R2 gap", 64'(res_vld), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule